// File: doc/BRIEF.md
# Dual-Tuning-Word Cosine Oscillator

This block is a numerically controlled oscillator that puts out one cosine amplitude code on every clock. It keeps two 32-bit tuning words and four 12-bit phase offsets in local registers, which are written through simple write-enable ports. On each clock a frequency select line picks one tuning word, and that word is added to a 32-bit phase accumulator. A phase select line picks one offset, and that offset is added, modulo 4096, to the top 12 bits of the accumulator. The resulting 12-bit phase addresses a cosine table. The table output is a 10-bit offset-binary amplitude, and the output frequency is the tuning word times the clock rate divided by 2^32.

Switching between tuning words only changes the step size. The accumulator keeps running, so the phase never jumps. Frequency-shift keying works by toggling the frequency select line, and phase-shift keying by stepping the phase select lines. The output is a free-running sample stream with no handshake. A new code is presented on every clock and cannot be held back, so a consumer must take every sample. A synchronous reset bit clears the accumulator and parks the output at midscale. It leaves the stored tuning words and offsets untouched.

Top module: `nco_dual_tone`

## Requirements
- R1: The 32-bit accumulator adds the selected tuning word on every clock edge outside reset, wrapping modulo 2^32. A tuning word of 2^30 yields an output sequence that repeats exactly every 4 samples.
- R2: freq_sel = 0 selects tuning word 0 and freq_sel = 1 selects tuning word 1. The select is sampled on every clock edge.
- R3: Changing freq_sel neither clears nor reloads the accumulator. The next accumulator value is the current value plus the newly selected word.
- R4: ofs_sel values 0..3 pick one of four 12-bit offsets. The offset is added modulo 4096 to accumulator bits [31:20]. An offset of 1024 advances the output by a quarter cycle.
- R5: For a 12-bit phase p, the output code is 512 + round(511*cos(2*pi*p/4096)) in offset binary. This gives p=0 -> 1023, p=1024 -> 512, p=2048 -> 1 and p=3072 -> 512. The code is never 0.
- R6: The sample registered on clock edge e uses the accumulator value stored on edge e-2, which was built with the freq_sel sampled on edge e-2, and the ofs_sel sampled on edge e-1.
- R7: When rst is high at an edge, the accumulator becomes 0 and amp_out becomes 512. On the first edge after rst falls, amp_out stays 512. On the second edge it shows the code for phase 0 plus the selected offset.
- R8: rst does not alter the stored tuning words or phase offsets.
- R9: A write with freq_we high loads freq_wr_word into tuning word freq_wr_idx on the clock edge. A write with ofs_we high loads ofs_wr_word into offset ofs_wr_idx. A word written on edge w is first used on edge w+1. Writes are accepted during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset: clears the accumulator and forces midscale output |
| freq_sel | input | 1 | Selects tuning word 0 or 1 |
| ofs_sel | input | 2 | Selects one of four phase offsets |
| freq_we | input | 1 | Tuning word write enable |
| freq_wr_idx | input | 1 | Index of the tuning word to write |
| freq_wr_word | input | 32 | Tuning word write data |
| ofs_we | input | 1 | Phase offset write enable |
| ofs_wr_idx | input | 2 | Index of the phase offset to write |
| ofs_wr_word | input | 12 | Phase offset write data |
| amp_out | output | 10 | Offset-binary cosine amplitude, one sample per clock |

## Verification
Each result has a fixed due cycle.
- **Tuning words:** a word or freq_sel change reaches the output two edges after the accumulator takes it, so it is visible on the third edge after it is applied.
- **Phase offsets:** an ofs_sel change is seen on the second edge.
- **Reset:** the midscale code is due one edge after reset, and the first real sample two edges after release.

The bench drives inputs on the falling edge and advances its own cycle model on the rising edge. It compares amp_out at the following falling edge, so every check lands on the exact edge the requirements name. Generic samples allow one code of rounding slack. The four quadrant points and the reset codes must match exactly.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Magnitude of a quarter-wave cosine sample, rounded to the nearest code.
  // idx runs 0..qlen, covering angles 0..pi/2 inclusive.
  function automatic int qcos_mag(input int idx, input int qlen, input int half);
    real ang;
    ang = 1.5707963267948966 * real'(idx) / real'(qlen);
    return $rtoi(real'(half) * $cos(ang) + 0.5);
  endfunction

endpackage

// File: rtl/nco_tuning_bank.sv
module nco_tuning_bank #(
  parameter int ACC_W  = 32,
  parameter int PH_W   = 12,
  parameter int N_FREQ = 2,
  parameter int N_OFS  = 4,
  parameter int FSW    = $clog2(N_FREQ),
  parameter int OSW    = $clog2(N_OFS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freq_we,
  input  logic [FSW-1:0]   freq_wr_idx,
  input  logic [ACC_W-1:0] freq_wr_word,
  input  logic             ofs_we,
  input  logic [OSW-1:0]   ofs_wr_idx,
  input  logic [PH_W-1:0]  ofs_wr_word,
  input  logic [FSW-1:0]   freq_sel,
  input  logic [OSW-1:0]   ofs_sel,
  output logic [ACC_W-1:0] step_o,
  output logic [PH_W-1:0]  ofs_o
);

  logic [ACC_W-1:0] freq_r [N_FREQ];
  logic [PH_W-1:0]  ofs_r  [N_OFS];

  // Storage has no reset on purpose: R8 keeps contents across rst.
  for (genvar g = 0; g < N_FREQ; g++) begin : g_freq
    always_ff @(posedge clk) begin
      if (freq_we && (freq_wr_idx == FSW'(g))) freq_r[g] <= freq_wr_word;
    end

    a_r9_freq_hold: assert property (@(posedge clk) disable iff (rst)
      !(freq_we && (freq_wr_idx == FSW'(g))) |=> $stable(freq_r[g]));
  end

  for (genvar g = 0; g < N_OFS; g++) begin : g_ofs
    always_ff @(posedge clk) begin
      if (ofs_we && (ofs_wr_idx == OSW'(g))) ofs_r[g] <= ofs_wr_word;
    end

    a_r9_ofs_hold: assert property (@(posedge clk) disable iff (rst)
      !(ofs_we && (ofs_wr_idx == OSW'(g))) |=> $stable(ofs_r[g]));
  end

  assign step_o = freq_r[freq_sel];
  assign ofs_o  = ofs_r[ofs_sel];

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] step_i,
  input  logic [PH_W-1:0]  ofs_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [PH_W-1:0]  phase_o,
  output logic             primed_o
);

  logic [ACC_W-1:0] acc_q;
  logic [PH_W-1:0]  phase_q;
  logic             primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      phase_q  <= '0;
      primed_q <= 1'b0;
    end else begin
      acc_q    <= acc_q + step_i;
      phase_q  <= acc_q[ACC_W-1 -: PH_W] + ofs_i;
      primed_q <= 1'b1;
    end
  end

  assign acc_o    = acc_q;
  assign phase_o  = phase_q;
  assign primed_o = primed_q;

  // R7: reset empties the accumulator and the pipeline
  a_r7_acc_clear: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && !primed_q);

endmodule

// File: rtl/nco_cos_rom.sv
module nco_cos_rom #(
  parameter int PH_W  = 12,
  parameter int AMP_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             valid_i,
  output logic [AMP_W-1:0] amp_o
);

  localparam int QW    = PH_W - 2;
  localparam int QLEN  = 1 << QW;
  localparam int MAG_W = AMP_W - 1;
  localparam int MID   = 1 << MAG_W;
  localparam int HALF  = MID - 1;

  // Quarter-wave table with one extra entry for the pi/2 point.
  logic [MAG_W-1:0] mag_tbl [QLEN+1];

  initial begin
    for (int i = 0; i <= QLEN; i++)
      mag_tbl[i] = MAG_W'(nco_pkg::qcos_mag(i, QLEN, HALF));
  end

  logic [1:0]       quad;
  logic [QW:0]      fold_idx;
  logic [MAG_W-1:0] mag;
  logic             negate;
  logic [AMP_W-1:0] code;

  always_comb begin
    quad     = phase_i[PH_W-1 -: 2];
    fold_idx = quad[0] ? ((QW+1)'(QLEN) - {1'b0, phase_i[QW-1:0]})
                       : {1'b0, phase_i[QW-1:0]};
    mag      = mag_tbl[fold_idx];
    negate   = (quad == 2'd1) || (quad == 2'd2);
    code     = negate ? (AMP_W'(MID) - {1'b0, mag})
                      : (AMP_W'(MID) + {1'b0, mag});
  end

  always_ff @(posedge clk) begin
    if (rst)          amp_o <= AMP_W'(MID);
    else if (valid_i) amp_o <= code;
    else              amp_o <= AMP_W'(MID);
  end

  // R5: offset-binary code never reaches zero
  a_r5_floor: assert property (@(posedge clk) disable iff (rst)
    $past(valid_i) |-> (amp_o != '0));

  // R7: output parks at midscale one edge after reset
  a_r7_mid_out: assert property (@(posedge clk)
    rst |=> (amp_o == AMP_W'(MID)));

endmodule

// File: rtl/nco_dual_tone.sv
module nco_dual_tone #(
  parameter int ACC_W  = 32,
  parameter int PH_W   = 12,
  parameter int AMP_W  = 10,
  parameter int N_FREQ = 2,
  parameter int N_OFS  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [$clog2(N_FREQ)-1:0] freq_sel,
  input  logic [$clog2(N_OFS)-1:0]  ofs_sel,
  input  logic                      freq_we,
  input  logic [$clog2(N_FREQ)-1:0] freq_wr_idx,
  input  logic [ACC_W-1:0]          freq_wr_word,
  input  logic                      ofs_we,
  input  logic [$clog2(N_OFS)-1:0]  ofs_wr_idx,
  input  logic [PH_W-1:0]           ofs_wr_word,
  output logic [AMP_W-1:0]          amp_out
);

  localparam int FSW = $clog2(N_FREQ);
  localparam int OSW = $clog2(N_OFS);

  logic [ACC_W-1:0] step_w;
  logic [ACC_W-1:0] acc_w;
  logic [PH_W-1:0]  ofs_w;
  logic [PH_W-1:0]  phase_w;
  logic             primed_w;

  nco_tuning_bank #(
    .ACC_W(ACC_W), .PH_W(PH_W), .N_FREQ(N_FREQ), .N_OFS(N_OFS),
    .FSW(FSW), .OSW(OSW)
  ) bank_i (
    .clk(clk), .rst(rst),
    .freq_we(freq_we), .freq_wr_idx(freq_wr_idx), .freq_wr_word(freq_wr_word),
    .ofs_we(ofs_we), .ofs_wr_idx(ofs_wr_idx), .ofs_wr_word(ofs_wr_word),
    .freq_sel(freq_sel), .ofs_sel(ofs_sel),
    .step_o(step_w), .ofs_o(ofs_w)
  );

  nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) acc_i (
    .clk(clk), .rst(rst), .step_i(step_w), .ofs_i(ofs_w),
    .acc_o(acc_w), .phase_o(phase_w), .primed_o(primed_w)
  );

  nco_cos_rom #(.PH_W(PH_W), .AMP_W(AMP_W)) rom_i (
    .clk(clk), .rst(rst), .phase_i(phase_w), .valid_i(primed_w),
    .amp_o(amp_out)
  );

  // R3: successive accumulator values differ by exactly the word the bank offered
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((acc_w - $past(acc_w)) == $past(step_w)));

endmodule

// File: tb/nco_dual_tone_tb.sv
`timescale 1ns/1ps
module nco_dual_tone_tb_top;

  localparam int MIDC = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        freq_sel = 1'b0;
  logic [1:0]  ofs_sel = 2'd0;
  logic        freq_we = 1'b0;
  logic        freq_wr_idx = 1'b0;
  logic [31:0] freq_wr_word = '0;
  logic        ofs_we = 1'b0;
  logic [1:0]  ofs_wr_idx = 2'd0;
  logic [11:0] ofs_wr_word = '0;
  logic [9:0]  amp_out;

  always #2.5 clk = ~clk;

  nco_dual_tone dut_i (
    .clk(clk), .rst(rst), .freq_sel(freq_sel), .ofs_sel(ofs_sel),
    .freq_we(freq_we), .freq_wr_idx(freq_wr_idx), .freq_wr_word(freq_wr_word),
    .ofs_we(ofs_we), .ofs_wr_idx(ofs_wr_idx), .ofs_wr_word(ofs_wr_word),
    .amp_out(amp_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Independent cycle model built from R1..R9
  logic [31:0] m_freq [2];
  logic [11:0] m_ofs  [4];
  logic [31:0] m_acc = '0;
  logic [11:0] m_phase = '0;
  bit          m_primed = 1'b0;
  int          m_amp = MIDC;

  function automatic int ref_cos(input int p);
    real c;
    c = 511.0 * $cos(2.0 * 3.14159265358979 * real'(p) / 4096.0);
    if (c >= 0.0) return MIDC + $rtoi(c + 0.5);
    else          return MIDC - $rtoi(-c + 0.5);
  endfunction

  task automatic check(input int act, input int exp, input int tol, input string req);
    int d;
    n_chk++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s: amp_out=%0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: edge, model update, then sample at the falling edge.
  task automatic tick(input bit do_chk, input string req);
    int          new_amp;
    logic [11:0] new_phase;
    @(posedge clk);
    if (rst) begin
      m_acc = '0; m_phase = '0; m_primed = 1'b0; m_amp = MIDC;
    end else begin
      new_amp   = m_primed ? ref_cos(int'(m_phase)) : MIDC;
      new_phase = m_acc[31:20] + m_ofs[ofs_sel];
      m_acc     = m_acc + m_freq[freq_sel];
      m_phase   = new_phase;
      m_primed  = 1'b1;
      m_amp     = new_amp;
    end
    if (freq_we) m_freq[freq_wr_idx] = freq_wr_word;
    if (ofs_we)  m_ofs[ofs_wr_idx]   = ofs_wr_word;
    @(negedge clk);
    if (do_chk) check(int'(amp_out), m_amp, 1, req);
  endtask

  task automatic wr_freq(input bit idx, input logic [31:0] w);
    freq_we = 1'b1; freq_wr_idx = idx; freq_wr_word = w;
    tick(1'b0, "R9");
    freq_we = 1'b0;
  endtask

  task automatic wr_ofs(input logic [1:0] idx, input logic [11:0] w);
    ofs_we = 1'b1; ofs_wr_idx = idx; ofs_wr_word = w;
    tick(1'b0, "R9");
    ofs_we = 1'b0;
  endtask

  // Vector table: {freq_sel, ofs_sel, cycles}
  localparam int NV = 8;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'd6},
    {1'b1, 2'd0, 8'd9},
    {1'b0, 2'd3, 8'd5},
    {1'b1, 2'd2, 8'd7},
    {1'b1, 2'd1, 8'd3},
    {1'b0, 2'd1, 8'd4},
    {1'b1, 2'd3, 8'd8},
    {1'b0, 2'd2, 8'd6}
  };

  int base_s [8];
  int shift_s [8];

  initial begin : watchdog
    #(5 * 20000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    @(negedge clk);
    // R9: load registers while in reset
    wr_freq(1'b0, 32'h4000_0000);
    wr_freq(1'b1, 32'h0123_4567);
    wr_ofs(2'd0, 12'd0);
    wr_ofs(2'd1, 12'd1024);
    wr_ofs(2'd2, 12'd2048);
    wr_ofs(2'd3, 12'd100);
    tick(1'b0, "R7");
    check(int'(amp_out), MIDC, 0, "R7 reset midscale");

    // R1 / R5 / R7: tuning word 2^30, offset 0
    rst = 1'b0; freq_sel = 1'b0; ofs_sel = 2'd0;
    tick(1'b0, "R7");
    check(int'(amp_out), MIDC, 0, "R7 first edge after release");
    for (int i = 0; i < 8; i++) begin
      tick(1'b1, "R6 model");
      base_s[i] = int'(amp_out);
    end
    check(base_s[0], 1023, 0, "R5 phase 0");
    check(base_s[1], 512, 0, "R5 phase 1024");
    check(base_s[2], 1, 0, "R5 phase 2048");
    check(base_s[3], 512, 0, "R5 phase 3072");
    for (int i = 0; i < 4; i++) check(base_s[i+4], base_s[i], 0, "R1 period 4");

    // R8 / R4: reset again, offsets and words must survive; offset 1024 -> quarter cycle
    rst = 1'b1;
    tick(1'b1, "R7");
    tick(1'b0, "R7");
    check(int'(amp_out), MIDC, 0, "R7 reset midscale again");
    rst = 1'b0; ofs_sel = 2'd1;
    tick(1'b1, "R7");
    for (int i = 0; i < 8; i++) begin
      tick(1'b1, "R8 model");
      shift_s[i] = int'(amp_out);
    end
    check(shift_s[0], 512, 0, "R8 offset kept across reset");
    for (int i = 0; i < 7; i++) check(shift_s[i], base_s[i+1], 0, "R4 quarter shift");

    // R6: offset change shows on the second edge
    ofs_sel = 2'd2;
    tick(1'b1, "R6");
    check(int'(amp_out), shift_s[0], 1, "R6 old offset still out one edge later");
    tick(1'b1, "R6");

    // R2 / R3 / R4 / R6: walk the vector table against the model
    for (int v = 0; v < NV; v++) begin
      freq_sel = VEC[v][10];
      ofs_sel  = VEC[v][9:8];
      for (int c = 0; c < int'(VEC[v][7:0]); c++) tick(1'b1, "R2 R3 R4 R6 table");
    end

    // R9: rewrite the active tuning word and offset while running
    freq_sel = 1'b0; ofs_sel = 2'd3;
    freq_we = 1'b1; freq_wr_idx = 1'b0; freq_wr_word = 32'h2000_0000;
    tick(1'b1, "R9 freq write");
    freq_we = 1'b0;
    ofs_we = 1'b1; ofs_wr_idx = 2'd3; ofs_wr_word = 12'd3000;
    tick(1'b1, "R9 ofs write");
    ofs_we = 1'b0;
    for (int c = 0; c < 10; c++) tick(1'b1, "R9 after writes");

    // R3: toggle frequency each cycle, FSK style
    for (int c = 0; c < 16; c++) begin
      freq_sel = ~freq_sel;
      tick(1'b1, "R3 continuity");
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule